// File: doc/BRIEF.md
# Interrupt Entry Context Saver

This block performs the hardware entry into an interrupt handler for a word-addressed processor with sixteen 32-bit registers. When an interrupt is raised with a number and a detail word, the block looks up the handler address in a vector table held in memory. The table entry sits at the vector base plus the interrupt number. The block then switches the processor into system mode and saves the interrupted context onto the system stack. The stack pointer and program counter are updated at the end.

The save is a fixed 17-word frame, and the block writes one word per cycle through a shared memory port. General registers come in through a register-file read port. The frame pointer and stack pointer are banked, so the values saved for them are the system-mode copies given on dedicated inputs. The flags word saved is the value captured before the system bit was set. When the vector base is zero, no handler can be reached. In that case the block raises a halt indication and touches nothing.

The program counter and stack pointer updates and a one-cycle done strobe come out together in the last cycle. No new interrupt is taken while a sequence is running.

Top module: `irq_entry_saver`

## Requirements
- R1: After reset, `busy`, `done`, `halt`, `mem_re`, `mem_we`, `flags_we`, `pc_we` and `sp_we` are all 0.
- R2: A request seen while `vec_base` is zero sets `halt`. `halt` stays set until reset. In that state there is no memory read, no memory write and no flags, PC or SP write, and later requests are ignored.
- R3: Take the clock edge at which a request is accepted as edge 0. In the cycle after edge 0, `mem_re` is 1 for exactly one cycle and `mem_addr` = `vec_base` + `irq_num`, with the number zero-extended.
- R4: `flags_we` is 1 in that same cycle and in no other. `flags_wdata` equals the flags captured at acceptance with bit 3 (the system-mode bit, value 8) set.
- R5: Take the captured system stack pointer as SP. Over the next 17 cycles `mem_we` is 1 and the slots are written in order: slot j goes to address SP-j. Slots 1..12 hold registers R0..R11.
- R6: Slot 13 holds the system frame pointer (`sys_fp`). Slot 14 holds the system stack pointer as it was at entry. Slot 15 holds the interrupted PC, read as register 15.
- R7: Slot 16 holds the detail word. Slot 17 holds the flags word as it was before the system bit was set.
- R8: In the cycle after slot 17, `done`, `pc_we` and `sp_we` are 1 for exactly one cycle. `pc_wdata` is the vector-table word and `sp_wdata` = SP-17. This cycle is 19 cycles after acceptance.
- R9: A request raised while `busy` is 1 is ignored. It causes no extra read, write or done strobe.
- R10: A memory read and a memory write are never requested in the same cycle. The first frame write directly follows the vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request, sampled while idle |
| irq_num | input | 8 | Interrupt number |
| irq_detail | input | 32 | Detail word to save |
| vec_base | input | 32 | Vector table base (zero means no handler) |
| flags_cur | input | 32 | Current flags word |
| sys_sp | input | 32 | System-mode stack pointer |
| sys_fp | input | 32 | System-mode frame pointer |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_re` |
| flags_we | output | 1 | Flags write strobe |
| flags_wdata | output | 32 | New flags word |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | Handler address |
| sp_we | output | 1 | System SP write strobe |
| sp_wdata | output | 32 | New system SP |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| halt | output | 1 | Sticky: vector base was zero |

## Verification
The hardest condition to reach is a second request arriving in the middle of a push. It must be dropped without disturbing the frame or adding a done strobe. Every table row raises a second request with a different number partway through the write burst. The bench then counts reads, writes and done strobes across the whole window. The sticky halt is reached by clearing the vector base before a request. A follow-up request with a valid base then confirms that the block stays inert until reset.

// File: rtl/ies_pkg.sv
package ies_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_VEC  = 2'd1,
      ST_PUSH = 2'd2,
      ST_FIN  = 2'd3
   } ies_state_e;

   typedef enum logic [2:0] {
      SRC_GPR,
      SRC_FP,
      SRC_SP,
      SRC_PC,
      SRC_DETAIL,
      SRC_FLAGS
   } ies_src_e;

   // Slot numbering starts at 1; general registers fill the first ngen slots.
   function automatic ies_src_e slot_source(input int unsigned slot, input int unsigned ngen);
      if (slot <= ngen)          return SRC_GPR;
      else if (slot == ngen + 1) return SRC_FP;
      else if (slot == ngen + 2) return SRC_SP;
      else if (slot == ngen + 3) return SRC_PC;
      else if (slot == ngen + 4) return SRC_DETAIL;
      else                       return SRC_FLAGS;
   endfunction

endpackage

// File: rtl/ies_ctrl.sv
module ies_ctrl
   import ies_pkg::*;
#(
   parameter int FRAME = 17,
   parameter int CW    = $clog2(FRAME + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             base_zero_i,
   output ies_state_e       state_o,
   output logic [CW-1:0]    slot_o,
   output logic             accept_o,
   output logic             halt_o,
   output logic             done_o
);

   generate
      if (FRAME < 2) begin : g_bad_frame
         $error("ies_ctrl: FRAME must be at least 2");
      end
   endgenerate

   ies_state_e    state_q;
   logic [CW-1:0] slot_q;
   logic          halt_q;

   assign accept_o = (state_q == ST_IDLE) && req_i && !base_zero_i && !halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         halt_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_i && !halt_q && base_zero_i) halt_q  <= 1'b1;
               if (accept_o)                        state_q <= ST_VEC;
            end
            ST_VEC: begin
               state_q <= ST_PUSH;
               slot_q  <= CW'(1);
            end
            ST_PUSH: begin
               if (slot_q == CW'(FRAME)) begin
                  state_q <= ST_FIN;
                  slot_q  <= '0;
               end else begin
                  slot_q <= slot_q + CW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign slot_o  = slot_q;
   assign halt_o  = halt_q;
   assign done_o  = (state_q == ST_FIN);

   // R8: completion strobe lasts one cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2: halt only ever coexists with the idle state
   a_r2_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> (state_q == ST_IDLE));

   // R9: no new sequence starts from the middle of a push
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PUSH) |=> (state_q != ST_VEC));

endmodule

// File: rtl/ies_frame.sv
module ies_frame
   import ies_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RIDX_W = 4,
   parameter int NGEN   = 12,
   parameter int CW     = 5
) (
   input  logic [CW-1:0]     slot_i,
   input  logic [DATA_W-1:0] sp_base_i,
   input  logic [DATA_W-1:0] fp_i,
   input  logic [DATA_W-1:0] detail_i,
   input  logic [DATA_W-1:0] flags_i,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic [RIDX_W-1:0] rf_raddr_o,
   output logic [DATA_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o
);

   localparam int NREG = 1 << RIDX_W;
   localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(NREG - 1);

   generate
      if (NGEN + 3 > NREG) begin : g_bad_ngen
         $error("ies_frame: NGEN too large for register index width");
      end
      if (NGEN + 5 >= (1 << CW)) begin : g_bad_cw
         $error("ies_frame: slot counter too narrow");
      end
   endgenerate

   ies_src_e      src;
   logic [CW-1:0] gpr_idx;

   assign src     = slot_source(32'(slot_i), NGEN);
   assign gpr_idx = slot_i - CW'(1);
   assign addr_o  = sp_base_i - DATA_W'(slot_i);

   always_comb begin
      rf_raddr_o = '0;
      wdata_o    = '0;
      case (src)
         SRC_GPR: begin
            rf_raddr_o = RIDX_W'(gpr_idx);
            wdata_o    = rf_rdata_i;
         end
         SRC_FP:     wdata_o = fp_i;
         SRC_SP:     wdata_o = sp_base_i;
         SRC_PC: begin
            rf_raddr_o = PC_IDX;
            wdata_o    = rf_rdata_i;
         end
         SRC_DETAIL: wdata_o = detail_i;
         default:    wdata_o = flags_i;
      endcase
   end

endmodule

// File: rtl/irq_entry_saver.sv
module irq_entry_saver
   import ies_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_W   = 8,
   parameter int RIDX_W  = 4,
   parameter int NGEN    = 12,
   parameter int SYS_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [NUM_W-1:0]  irq_num,
   input  logic [DATA_W-1:0] irq_detail,
   input  logic [DATA_W-1:0] vec_base,
   input  logic [DATA_W-1:0] flags_cur,
   input  logic [DATA_W-1:0] sys_sp,
   input  logic [DATA_W-1:0] sys_fp,
   output logic [RIDX_W-1:0] rf_raddr,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              mem_re,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              flags_we,
   output logic [DATA_W-1:0] flags_wdata,
   output logic              pc_we,
   output logic [DATA_W-1:0] pc_wdata,
   output logic              sp_we,
   output logic [DATA_W-1:0] sp_wdata,
   output logic              busy,
   output logic              done,
   output logic              halt
);

   localparam int FRAME = NGEN + 5;
   localparam int CW    = $clog2(FRAME + 1);
   localparam logic [DATA_W-1:0] SYS_MASK = DATA_W'(1) << SYS_BIT;

   generate
      if (SYS_BIT >= DATA_W) begin : g_bad_sysbit
         $error("irq_entry_saver: SYS_BIT outside the flags word");
      end
      if (NUM_W > DATA_W) begin : g_bad_numw
         $error("irq_entry_saver: NUM_W wider than the data path");
      end
   endgenerate

   ies_state_e        state;
   logic [CW-1:0]     slot;
   logic              accept;
   logic [NUM_W-1:0]  num_q;
   logic [DATA_W-1:0] det_q, flg_q, sp_q, fp_q, base_q, pc_new_q;
   logic [DATA_W-1:0] push_addr, push_data;

   ies_ctrl #(.FRAME(FRAME), .CW(CW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (irq_req),
      .base_zero_i (vec_base == '0),
      .state_o     (state),
      .slot_o      (slot),
      .accept_o    (accept),
      .halt_o      (halt),
      .done_o      (done)
   );

   ies_frame #(.DATA_W(DATA_W), .RIDX_W(RIDX_W), .NGEN(NGEN), .CW(CW)) u_frame (
      .slot_i     (slot),
      .sp_base_i  (sp_q),
      .fp_i       (fp_q),
      .detail_i   (det_q),
      .flags_i    (flg_q),
      .rf_rdata_i (rf_rdata),
      .rf_raddr_o (rf_raddr),
      .addr_o     (push_addr),
      .wdata_o    (push_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q    <= '0;
         det_q    <= '0;
         flg_q    <= '0;
         sp_q     <= '0;
         fp_q     <= '0;
         base_q   <= '0;
         pc_new_q <= '0;
      end else begin
         if (accept) begin
            num_q  <= irq_num;
            det_q  <= irq_detail;
            flg_q  <= flags_cur;
            sp_q   <= sys_sp;
            fp_q   <= sys_fp;
            base_q <= vec_base;
         end
         if (state == ST_PUSH && slot == CW'(1)) pc_new_q <= mem_rdata;
      end
   end

   assign mem_re      = (state == ST_VEC);
   assign mem_we      = (state == ST_PUSH);
   assign mem_addr    = mem_re ? (base_q + DATA_W'(num_q)) : (mem_we ? push_addr : '0);
   assign mem_wdata   = mem_we ? push_data : '0;
   assign flags_we    = (state == ST_VEC);
   assign flags_wdata = flg_q | SYS_MASK;
   assign pc_we       = done;
   assign pc_wdata    = pc_new_q;
   assign sp_we       = done;
   assign sp_wdata    = sp_q - DATA_W'(FRAME);
   assign busy        = (state != ST_IDLE);

   // R10: single memory access per cycle
   a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R10: the write burst opens right after the vector read
   a_r10_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(mem_re));

   // R5: consecutive frame writes step down by one word
   a_r5_addr_descends: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - DATA_W'(1)));

   // R2: a halted block is silent
   a_r2_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (!mem_re && !mem_we && !busy && !flags_we));

   // R8: SP and PC updates come only with the completion strobe
   a_r8_update_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we || pc_we) |-> (done && sp_we && pc_we));

   // R8: completion follows the last write
   a_r8_done_after_push: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_we));

endmodule

// File: tb/irq_entry_saver_bench.sv
module irq_entry_saver_bench;

   typedef struct packed {
      logic [7:0]  num;
      logic [31:0] det;
      logic [31:0] flg;
      logic [31:0] sp;
      logic [31:0] fp;
      logic [31:0] base;
      logic [31:0] handler;
   } vec_t;

   localparam int NROW = 4;
   localparam vec_t TBL [NROW] = '{
      '{8'd2,    32'h0000_00A5, 32'h0000_0001, 32'h0000_00C0, 32'h1111_0000, 32'h0000_0010, 32'h0000_4000},
      '{8'd7,    32'hDEAD_BEEF, 32'h0000_0006, 32'h0000_0080, 32'h2222_2222, 32'h0000_0020, 32'h0000_5550},
      '{8'd0,    32'h0000_0000, 32'h0000_000F, 32'h0000_0060, 32'h0000_0003, 32'h0000_0030, 32'h0000_1234},
      '{8'hF0,   32'h8000_0001, 32'h0000_0010, 32'h0000_0040, 32'h0000_0000, 32'h0000_000F, 32'hFFFF_FFFF}
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic        irq_req = 0;
   logic [7:0]  irq_num = 0;
   logic [31:0] irq_detail = 0, vec_base = 0, flags_cur = 0, sys_sp = 0, sys_fp = 0;
   logic [3:0]  rf_raddr;
   logic [31:0] rf_rdata;
   logic        mem_re, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata;
   logic        flags_we, pc_we, sp_we, busy, done, halt;
   logic [31:0] flags_wdata, pc_wdata, sp_wdata;

   logic [31:0] rf [16];
   logic [31:0] mem [256];
   logic [31:0] wlog [64];
   int          wr_cnt = 0, rd_cnt = 0;
   logic        tb_we = 0;
   logic [7:0]  tb_addr = 0;
   logic [31:0] tb_data = 0;

   int tests = 0, fails = 0;

   always #5 clk = ~clk;

   assign rf_rdata = rf[rf_raddr];

   always @(posedge clk) begin
      if (tb_we) mem[tb_addr] <= tb_data;
      if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wlog[wr_cnt % 64]  <= mem_addr;
         wr_cnt             <= wr_cnt + 1;
      end
      if (mem_re) begin
         mem_rdata <= mem[mem_addr[7:0]];
         rd_cnt    <= rd_cnt + 1;
      end
   end

   irq_entry_saver u_irq_entry_saver (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
      .irq_detail(irq_detail), .vec_base(vec_base), .flags_cur(flags_cur),
      .sys_sp(sys_sp), .sys_fp(sys_fp), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .flags_we(flags_we), .flags_wdata(flags_wdata),
      .pc_we(pc_we), .pc_wdata(pc_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
      .busy(busy), .done(done), .halt(halt)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1; tb_addr = a; tb_data = d;
      @(negedge clk);
      tb_we = 0;
   endtask

   task automatic check_idle(input string req);
      chk(!busy && !done && !halt && !mem_re && !mem_we && !flags_we && !pc_we && !sp_we,
          req, {24'd0, busy, done, halt, mem_re, mem_we, flags_we, pc_we, sp_we}, 32'd0);
   endtask

   task automatic run_row(input int r);
      vec_t v;
      int wr0, rd0, fl_cyc, fl_n, rd_cyc, done_cyc, done_n, wfirst;
      logic [31:0] fl_val, rd_addr, pc_v, sp_v, expw;
      v = TBL[r];
      for (int i = 0; i < 16; i++) rf[i] = 32'hA000_0000 | (r << 8) | i;
      poke(v.base[7:0] + v.num, v.handler);
      fl_cyc = -1; fl_n = 0; rd_cyc = -1; done_cyc = -1; done_n = 0; wfirst = -1;
      fl_val = 0; rd_addr = 0; pc_v = 0; sp_v = 0;
      @(negedge clk);
      wr0 = wr_cnt; rd0 = rd_cnt;
      irq_num = v.num; irq_detail = v.det; vec_base = v.base; flags_cur = v.flg;
      sys_sp = v.sp; sys_fp = v.fp; irq_req = 1;
      for (int c = 1; c <= 24; c++) begin
         @(negedge clk);
         irq_req = 0;
         // R9: a second request in the middle of the burst, with other inputs
         if (c == 5) begin
            irq_req = 1; irq_num = v.num + 8'd1; sys_sp = 32'h0000_0010;
            flags_cur = 32'hFFFF_FFF7;
         end
         if (flags_we) begin fl_n++; fl_cyc = c; fl_val = flags_wdata; end
         if (mem_re) begin rd_cyc = c; rd_addr = mem_addr; end
         if (mem_we && wfirst < 0) wfirst = c;
         if (done) begin done_n++; done_cyc = c; pc_v = pc_wdata; sp_v = sp_wdata; end
      end
      // R3: vector read address and timing
      chk(rd_cyc == 1 && rd_cnt - rd0 == 1, "R3 vector read cycle", rd_cyc, 1);
      chk(rd_addr == v.base + {24'd0, v.num}, "R3 vector address", rd_addr, v.base + {24'd0, v.num});
      // R4: mode switch
      chk(fl_cyc == 1 && fl_n == 1, "R4 flags write cycle", fl_cyc, 1);
      chk(fl_val == (v.flg | 32'h8), "R4 flags value", fl_val, v.flg | 32'h8);
      // R10: writes start right after the read
      chk(wfirst == 2, "R10 first write cycle", wfirst, 2);
      // R8: completion
      chk(done_cyc == 19 && done_n == 1, "R8 done timing", done_cyc, 19);
      chk(pc_v == v.handler, "R8 new PC", pc_v, v.handler);
      chk(sp_v == v.sp - 32'd17, "R8 new SP", sp_v, v.sp - 32'd17);
      // R9: exactly one frame written
      chk(wr_cnt - wr0 == 17 && !busy, "R9 busy request ignored", wr_cnt - wr0, 17);
      for (int j = 1; j <= 17; j++) begin
         if (j <= 12)      expw = rf[j-1];
         else if (j == 13) expw = v.fp;
         else if (j == 14) expw = v.sp;
         else if (j == 15) expw = rf[15];
         else if (j == 16) expw = v.det;
         else              expw = v.flg;
         chk(wlog[(wr0 + j - 1) % 64] == v.sp - j, "R5 write order", wlog[(wr0 + j - 1) % 64], v.sp - j);
         if (j <= 12)      chk(mem[v.sp[7:0] - j] == expw, "R5 saved register", mem[v.sp[7:0] - j], expw);
         else if (j <= 15) chk(mem[v.sp[7:0] - j] == expw, "R6 banked or PC slot", mem[v.sp[7:0] - j], expw);
         else              chk(mem[v.sp[7:0] - j] == expw, "R7 detail or flags slot", mem[v.sp[7:0] - j], expw);
      end
   endtask

   initial begin
      int wr0, rd0, fl_seen;
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      for (int i = 0; i < 16; i++) rf[i] = 32'h0;
      repeat (3) @(negedge clk);
      check_idle("R1 during reset");
      rst_n = 1;
      @(negedge clk);
      check_idle("R1 after reset");

      for (int r = 0; r < NROW; r++) run_row(r);

      // R2: zero vector base halts
      @(negedge clk);
      wr0 = wr_cnt; rd0 = rd_cnt; fl_seen = 0;
      vec_base = 0; irq_num = 8'd3; sys_sp = 32'hC0; irq_req = 1;
      @(negedge clk);
      irq_req = 0;
      chk(halt == 1'b1, "R2 halt raised", halt, 1);
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (flags_we || pc_we || sp_we || busy) fl_seen++;
      end
      // R2: later request with a valid base stays ignored
      vec_base = 32'h10; irq_req = 1;
      for (int c = 0; c < 25; c++) begin
         @(negedge clk);
         irq_req = 0;
         if (flags_we || pc_we || sp_we || busy) fl_seen++;
      end
      chk(halt == 1'b1, "R2 halt sticky", halt, 1);
      chk(wr_cnt == wr0 && rd_cnt == rd0, "R2 no memory traffic", wr_cnt - wr0 + rd_cnt - rd0, 0);
      chk(fl_seen == 0, "R2 no register updates", fl_seen, 0);

      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_idle("R1 reset clears halt");

      // R10 and R3 again after halt recovery
      run_row(1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule